// File: doc/BRIEF.md
# Deterministic Particle Swarm Updater

This block holds the full state of a small particle swarm: for every agent and every dimension a position, a velocity and a personal-best position, plus one global-best vector and the fitness figures that go with the bests. A pulse on `start` launches one swarm step. The block then walks the agents in ascending order, and the dimensions of each agent in ascending order inside that. It updates exactly one (agent, dimension) element per clock. Each new element is also presented on an update stream, so an external evaluator can follow the new positions as they are produced.

The update rule has no random terms. The velocity is pulled one eighth of the way toward the personal best and one sixteenth toward the global best. It is then limited to a per-dimension magnitude. The position moves by the old velocity and is held inside a per-dimension window. Fitness figures are computed outside the block and come back through a valid/ready handshake, where a lower figure is better. They replace personal and global bests under a strict-improvement rule with a fixed tie order.

All values are 16-bit signed fixed point with 8 fractional bits. Division by 8 and by 16 is done with arithmetic right shifts, which round toward minus infinity.

Top module: `pso_swarm_core`

## Requirements
- R1: After a synchronous reset, agent 0 sits at the upper bound of every dimension with velocity -vmax, and agent 1 sits at the lower bound with velocity +vmax. Every other agent a sits at lo + (((hi-lo)*a) >>> ceil(log2(agents))), with velocity +(vmax>>>1) for even a and -(vmax>>>1) for odd a. Each personal best equals the starting position, and each personal fitness is all ones. The global best is lo + ((hi-lo)>>>1), the global fitness is all ones, and the global agent is 0.
- R2: The new position is the pre-step position plus the pre-step velocity, held within [lo, hi] of that dimension.
- R3: The new velocity is v + ((P-x)>>>3) + ((G-x)>>>4). It uses pre-step x and v, the stored personal best P and the global best G. The sums are formed without wrap-around.
- R4: The new velocity is limited to the range [-vmax, +vmax] of its dimension.
- R5: `start` while idle raises `busy` for exactly agents*dims cycles, with elements updated in order agent-major, dimension-minor. `step_done` pulses for one cycle right after the last element. A `start` while `busy` is ignored.
- R6: A fitness is accepted only in a cycle with `fit_valid` and `fit_ready` both high. `fit_ready` is low whenever `busy` is high. A value offered while busy changes no best.
- R7: An accepted fitness strictly lower than the agent's stored fitness copies the agent's current position into its personal best and stores the fitness. An equal or higher value changes nothing.
- R8: An accepted fitness replaces the global best vector, fitness and agent when it is strictly lower than the global fitness, or equal to it from an agent with a lower index than the current global agent.
- R9: The read port returns position, velocity and personal best of (`rd_agent`, `rd_dim`), and the global best of `rd_dim`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lo_bound | input | DIMS*16 | Per-dimension lower position bound, dimension d at bits d*16 upward |
| hi_bound | input | DIMS*16 | Per-dimension upper position bound |
| vel_max | input | DIMS*16 | Per-dimension velocity magnitude limit (non-negative) |
| start | input | 1 | Begin one swarm step |
| busy | output | 1 | Step in progress |
| step_done | output | 1 | One-cycle pulse after the last element of a step |
| upd_valid | output | 1 | Update stream element valid |
| upd_agent | output | 4 | Agent of the updated element |
| upd_dim | output | 2 | Dimension of the updated element |
| upd_pos | output | 16 | New position |
| upd_vel | output | 16 | New velocity |
| fit_valid | input | 1 | Fitness offered |
| fit_ready | output | 1 | Fitness can be taken |
| fit_agent | input | 4 | Agent the fitness belongs to |
| fit_value | input | 16 | Fitness, unsigned, lower is better |
| rd_agent | input | 4 | Read port agent index |
| rd_dim | input | 2 | Read port dimension index |
| rd_pos | output | 16 | Position at the read index |
| rd_vel | output | 16 | Velocity at the read index |
| rd_pbest | output | 16 | Personal best at the read index |
| rd_gbest | output | 16 | Global best at the read dimension |
| gbest_fit | output | 16 | Global best fitness |
| gbest_agent | output | 4 | Agent that set the global best |

## Verification
The hardest situation to reach is a clamp on position, because it needs a velocity that is large compared with the window. One dimension is therefore given a velocity limit close to its span. Within two steps an agent started near the top overshoots the upper bound, and agent 0's first step drives its velocity past -vmax. The tie rule of the global best needs equal fitness values from a higher and then a lower agent index. Replacement of a personal best also needs a step in between, so that position and stored best differ and the figures can show that nothing was copied. The bench sends such fitness sequences on purpose and then reads the full state back.

// File: rtl/pso_swarm_core.sv
module pso_swarm_core #(
  parameter int N_AGENTS = 10,
  parameter int N_DIMS   = 4,
  parameter int W        = 16,
  parameter int FW       = 16,
  localparam int AW = $clog2(N_AGENTS),
  localparam int DW = (N_DIMS > 1) ? $clog2(N_DIMS) : 1,
  localparam int SH = $clog2(N_AGENTS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_DIMS*W-1:0]        lo_bound,
  input  logic [N_DIMS*W-1:0]        hi_bound,
  input  logic [N_DIMS*W-1:0]        vel_max,
  input  logic                       start,
  output logic                       busy,
  output logic                       step_done,
  output logic                       upd_valid,
  output logic [AW-1:0]              upd_agent,
  output logic [DW-1:0]              upd_dim,
  output logic signed [W-1:0]        upd_pos,
  output logic signed [W-1:0]        upd_vel,
  input  logic                       fit_valid,
  output logic                       fit_ready,
  input  logic [AW-1:0]              fit_agent,
  input  logic [FW-1:0]              fit_value,
  input  logic [AW-1:0]              rd_agent,
  input  logic [DW-1:0]              rd_dim,
  output logic signed [W-1:0]        rd_pos,
  output logic signed [W-1:0]        rd_vel,
  output logic signed [W-1:0]        rd_pbest,
  output logic signed [W-1:0]        rd_gbest,
  output logic [FW-1:0]              gbest_fit,
  output logic [AW-1:0]              gbest_agent
);

  logic signed [W-1:0] xs [N_AGENTS][N_DIMS];
  logic signed [W-1:0] vs [N_AGENTS][N_DIMS];
  logic signed [W-1:0] ps [N_AGENTS][N_DIMS];
  logic signed [W-1:0] gb [N_DIMS];
  logic [FW-1:0]       pf [N_AGENTS];

  logic [AW-1:0] cur_a;
  logic [DW-1:0] cur_d;

  function automatic logic signed [W-1:0] start_pos(int a, logic signed [W-1:0] lo,
                                                    logic signed [W-1:0] hi);
    int span;
    span = int'(hi) - int'(lo);
    if (a == 0) return hi;
    if (a == 1) return lo;
    return W'(int'(lo) + ((span * a) >>> SH));
  endfunction

  function automatic logic signed [W-1:0] start_vel(int a, logic [W-1:0] vm);
    int m;
    m = int'({1'b0, vm});
    if (a == 0) return W'(-m);
    if (a == 1) return W'(m);
    return (a % 2 == 0) ? W'(m >>> 1) : W'(-(m >>> 1));
  endfunction

  function automatic logic signed [W-1:0] mid_pos(logic signed [W-1:0] lo,
                                                  logic signed [W-1:0] hi);
    int span;
    span = int'(hi) - int'(lo);
    return W'(int'(lo) + (span >>> 1));
  endfunction

  // element datapath
  logic signed [W-1:0] xc, vc, pc, gc, lo_c, hi_c;
  logic signed [W:0]   vm_c, dp, dg;
  logic signed [W+2:0] v_sum;
  logic signed [W:0]   x_sum;
  logic signed [W-1:0] v_new, x_new;

  assign xc   = xs[cur_a][cur_d];
  assign vc   = vs[cur_a][cur_d];
  assign pc   = ps[cur_a][cur_d];
  assign gc   = gb[cur_d];
  assign lo_c = lo_bound[cur_d*W +: W];
  assign hi_c = hi_bound[cur_d*W +: W];
  assign vm_c = $signed({1'b0, vel_max[cur_d*W +: W]});

  assign dp    = pc - xc;
  assign dg    = gc - xc;
  assign v_sum = vc + (dp >>> 3) + (dg >>> 4);
  assign x_sum = xc + vc;

  always_comb begin
    if (v_sum > vm_c)       v_new = W'(vm_c);
    else if (v_sum < -vm_c) v_new = W'(-vm_c);
    else                    v_new = W'(v_sum);
    if (x_sum > hi_c)       x_new = hi_c;
    else if (x_sum < lo_c)  x_new = lo_c;
    else                    x_new = W'(x_sum);
  end

  // fitness decisions
  logic fit_acc, p_better, g_better;
  assign fit_ready = !busy;
  assign fit_acc   = fit_valid && fit_ready && (int'(fit_agent) < N_AGENTS);
  assign p_better  = fit_acc && (fit_value < pf[fit_agent]);
  assign g_better  = fit_acc && ((fit_value < gbest_fit) ||
                                 (fit_value == gbest_fit && fit_agent < gbest_agent));

  wire last_d = (int'(cur_d) == N_DIMS - 1);
  wire last_a = (int'(cur_a) == N_AGENTS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      step_done   <= 1'b0;
      upd_valid   <= 1'b0;
      upd_agent   <= '0;
      upd_dim     <= '0;
      upd_pos     <= '0;
      upd_vel     <= '0;
      cur_a       <= '0;
      cur_d       <= '0;
      gbest_fit   <= '1;
      gbest_agent <= '0;
      for (int a = 0; a < N_AGENTS; a++) begin
        pf[a] <= '1;
        for (int d = 0; d < N_DIMS; d++) begin
          xs[a][d] <= start_pos(a, lo_bound[d*W +: W], hi_bound[d*W +: W]);
          ps[a][d] <= start_pos(a, lo_bound[d*W +: W], hi_bound[d*W +: W]);
          vs[a][d] <= start_vel(a, vel_max[d*W +: W]);
        end
      end
      for (int d = 0; d < N_DIMS; d++)
        gb[d] <= mid_pos(lo_bound[d*W +: W], hi_bound[d*W +: W]);
    end else begin
      step_done <= 1'b0;
      upd_valid <= 1'b0;
      if (busy) begin
        xs[cur_a][cur_d] <= x_new;
        vs[cur_a][cur_d] <= v_new;
        upd_valid <= 1'b1;
        upd_agent <= cur_a;
        upd_dim   <= cur_d;
        upd_pos   <= x_new;
        upd_vel   <= v_new;
        if (last_d) begin
          cur_d <= '0;
          if (last_a) begin
            cur_a     <= '0;
            busy      <= 1'b0;
            step_done <= 1'b1;
          end else begin
            cur_a <= cur_a + 1'b1;
          end
        end else begin
          cur_d <= cur_d + 1'b1;
        end
      end else if (start) begin
        busy <= 1'b1;
      end
      if (p_better) begin
        pf[fit_agent] <= fit_value;
        for (int d = 0; d < N_DIMS; d++) ps[fit_agent][d] <= xs[fit_agent][d];
      end
      if (g_better) begin
        gbest_fit   <= fit_value;
        gbest_agent <= fit_agent;
        for (int d = 0; d < N_DIMS; d++) gb[d] <= xs[fit_agent][d];
      end
    end
  end

  wire rd_ok = (int'(rd_agent) < N_AGENTS) && (int'(rd_dim) < N_DIMS);
  assign rd_pos   = rd_ok ? xs[rd_agent][rd_dim] : '0;
  assign rd_vel   = rd_ok ? vs[rd_agent][rd_dim] : '0;
  assign rd_pbest = rd_ok ? ps[rd_agent][rd_dim] : '0;
  assign rd_gbest = (int'(rd_dim) < N_DIMS) ? gb[rd_dim] : '0;

endmodule

// File: rtl/pso_swarm_checks.sv
module pso_swarm_checks #(
  parameter int N_AGENTS = 10,
  parameter int N_DIMS   = 4,
  parameter int W        = 16,
  parameter int FW       = 16,
  localparam int DW = (N_DIMS > 1) ? $clog2(N_DIMS) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                busy,
  input logic                step_done,
  input logic                fit_ready,
  input logic                upd_valid,
  input logic [DW-1:0]       upd_dim,
  input logic signed [W-1:0] upd_pos,
  input logic signed [W-1:0] upd_vel,
  input logic [N_DIMS*W-1:0] lo_bound,
  input logic [N_DIMS*W-1:0] hi_bound,
  input logic [N_DIMS*W-1:0] vel_max,
  input logic [FW-1:0]       gbest_fit
);
  logic signed [W-1:0] lo_u, hi_u;
  logic signed [W:0]   vm_u;
  assign lo_u = lo_bound[upd_dim*W +: W];
  assign hi_u = hi_bound[upd_dim*W +: W];
  assign vm_u = $signed({1'b0, vel_max[upd_dim*W +: W]});

  assert_pos_window_R2: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> (upd_pos >= lo_u && upd_pos <= hi_u));

  assert_vel_limit_R4: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> (upd_vel <= vm_u && upd_vel >= -vm_u));

  assert_done_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> step_done);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    step_done |=> !step_done);

  assert_stream_while_step_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(upd_valid) |-> busy);

  assert_ready_idle_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !fit_ready);

  assert_gfit_never_up_R8: assert property (@(posedge clk) disable iff (rst)
    gbest_fit <= $past(gbest_fit));
endmodule

bind pso_swarm_core pso_swarm_checks #(
  .N_AGENTS(N_AGENTS), .N_DIMS(N_DIMS), .W(W), .FW(FW)
) u_checks (
  .clk(clk), .rst(rst), .busy(busy), .step_done(step_done), .fit_ready(fit_ready),
  .upd_valid(upd_valid), .upd_dim(upd_dim), .upd_pos(upd_pos), .upd_vel(upd_vel),
  .lo_bound(lo_bound), .hi_bound(hi_bound), .vel_max(vel_max), .gbest_fit(gbest_fit)
);

// File: tb/test_pso_swarm_core.sv
module test_pso_swarm_core;
  localparam int A = 10;
  localparam int D = 4;
  localparam int W = 16;
  localparam int SH = 4;

  logic clk = 0;
  always #10 clk = ~clk;

  logic rst, start, fit_valid;
  logic [D*W-1:0] lo_bound, hi_bound, vel_max;
  logic busy, step_done, upd_valid, fit_ready;
  logic [3:0] upd_agent, fit_agent, rd_agent, gbest_agent;
  logic [1:0] upd_dim, rd_dim;
  logic signed [W-1:0] upd_pos, upd_vel, rd_pos, rd_vel, rd_pbest, rd_gbest;
  logic [15:0] fit_value, gbest_fit;

  pso_swarm_core i_pso_swarm_core (
    .clk(clk), .rst(rst), .lo_bound(lo_bound), .hi_bound(hi_bound), .vel_max(vel_max),
    .start(start), .busy(busy), .step_done(step_done), .upd_valid(upd_valid),
    .upd_agent(upd_agent), .upd_dim(upd_dim), .upd_pos(upd_pos), .upd_vel(upd_vel),
    .fit_valid(fit_valid), .fit_ready(fit_ready), .fit_agent(fit_agent),
    .fit_value(fit_value), .rd_agent(rd_agent), .rd_dim(rd_dim), .rd_pos(rd_pos),
    .rd_vel(rd_vel), .rd_pbest(rd_pbest), .rd_gbest(rd_gbest),
    .gbest_fit(gbest_fit), .gbest_agent(gbest_agent)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  int lo[D] = '{-1536, 0, -512, -3072};
  int hi[D] = '{1536, 256, 1024, -1024};
  int vm[D] = '{256, 200, 96, 400};

  int mx[A][D], mv[A][D], mp[A][D], mg[D];
  int mpf[A];
  int mgf, mga;

  typedef struct { int a; int d; int x; int v; } item_t;
  item_t q[$];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clampi(int val, int l, int h);
    return (val > h) ? h : (val < l) ? l : val;
  endfunction

  // model reset state (R1)
  task automatic model_reset();
    for (int a = 0; a < A; a++) begin
      mpf[a] = 'hFFFF;
      for (int d = 0; d < D; d++) begin
        if (a == 0) begin mx[a][d] = hi[d]; mv[a][d] = -vm[d]; end
        else if (a == 1) begin mx[a][d] = lo[d]; mv[a][d] = vm[d]; end
        else begin
          mx[a][d] = lo[d] + (((hi[d] - lo[d]) * a) >>> SH);
          mv[a][d] = (a % 2 == 0) ? (vm[d] >>> 1) : -(vm[d] >>> 1);
        end
        mp[a][d] = mx[a][d];
      end
    end
    for (int d = 0; d < D; d++) mg[d] = lo[d] + ((hi[d] - lo[d]) >>> 1);
    mgf = 'hFFFF;
    mga = 0;
  endtask

  task automatic check_state(string tag);
    for (int a = 0; a < A; a++)
      for (int d = 0; d < D; d++) begin
        @(negedge clk);
        rd_agent = 4'(a);
        rd_dim = 2'(d);
        #1;
        chk({tag, "/R9"}, $sformatf("pos[%0d][%0d]", a, d), int'(rd_pos), mx[a][d]);
        chk({tag, "/R9"}, $sformatf("vel[%0d][%0d]", a, d), int'(rd_vel), mv[a][d]);
        chk({tag, "/R7"}, $sformatf("pbest[%0d][%0d]", a, d), int'(rd_pbest), mp[a][d]);
        if (a == 0) chk({tag, "/R8"}, $sformatf("gbest[%0d]", d), int'(rd_gbest), mg[d]);
      end
    chk({tag, "/R8"}, "gbest_fit", int'(gbest_fit), mgf);
    chk({tag, "/R8"}, "gbest_agent", int'(gbest_agent), mga);
  endtask

  // driver: compute expected stream (R2 R3 R4), then launch a step
  task automatic run_step(bit poke_busy);
    int nx[A][D], nv[A][D];
    int busy_cnt = 0, done_cnt = 0, guard = 0;
    for (int a = 0; a < A; a++)
      for (int d = 0; d < D; d++) begin
        nv[a][d] = clampi(mv[a][d] + ((mp[a][d] - mx[a][d]) >>> 3)
                          + ((mg[d] - mx[a][d]) >>> 4), -vm[d], vm[d]);
        nx[a][d] = clampi(mx[a][d] + mv[a][d], lo[d], hi[d]);
        q.push_back('{a, d, nx[a][d], nv[a][d]});
      end
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    forever begin
      if (busy) busy_cnt++;
      if (step_done) done_cnt++;
      if (busy_cnt == 3) start = 1;            // R5: ignored while busy
      else start = 0;
      if (poke_busy && busy_cnt == 5) begin    // R6: offer while busy
        chk("R6", "fit_ready while busy", int'(fit_ready), 0);
        fit_valid = 1; fit_agent = 4'd3; fit_value = 16'd1;
      end else fit_valid = 0;
      if (step_done || guard > 100) break;
      guard++;
      @(negedge clk);
    end
    start = 0;
    fit_valid = 0;
    @(negedge clk);
    chk("R5", "busy cycles per step", busy_cnt, A * D);
    chk("R5", "step_done pulses", done_cnt, 1);
    chk("R5", "busy after step", int'(busy), 0);
    chk("R5", "step_done cleared", int'(step_done), 0);
    chk("R5", "stream items left", q.size(), 0);
    for (int a = 0; a < A; a++)
      for (int d = 0; d < D; d++) begin
        mx[a][d] = nx[a][d];
        mv[a][d] = nv[a][d];
      end
  endtask

  task automatic send_fit(int a, int val);
    @(negedge clk);
    chk("R6", "fit_ready idle", int'(fit_ready), 1);
    fit_valid = 1; fit_agent = 4'(a); fit_value = 16'(val);
    @(negedge clk);
    fit_valid = 0;
    if (val < mpf[a]) begin
      mpf[a] = val;
      for (int d = 0; d < D; d++) mp[a][d] = mx[a][d];
    end
    if (val < mgf || (val == mgf && a < mga)) begin
      mgf = val; mga = a;
      for (int d = 0; d < D; d++) mg[d] = mx[a][d];
    end
  endtask

  // monitor: pops expected items as the design emits them
  always @(negedge clk) begin
    if (!rst && upd_valid) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5 unexpected stream item: actual=%0d/%0d expected=none", upd_agent, upd_dim);
      end else begin
        item_t e;
        e = q.pop_front();
        chk("R5", "stream agent", int'(upd_agent), e.a);
        chk("R5", "stream dim", int'(upd_dim), e.d);
        chk("R2", $sformatf("new pos [%0d][%0d]", e.a, e.d), int'(upd_pos), e.x);
        chk("R3/R4", $sformatf("new vel [%0d][%0d]", e.a, e.d), int'(upd_vel), e.v);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < D; d++) begin
      lo_bound[d*W +: W] = 16'(lo[d]);
      hi_bound[d*W +: W] = 16'(hi[d]);
      vel_max[d*W +: W]  = 16'(vm[d]);
    end
    rst = 1; start = 0; fit_valid = 0; fit_agent = 0; fit_value = 0;
    rd_agent = 0; rd_dim = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
    #1;
    chk("R1", "busy at reset", int'(busy), 0);
    chk("R6", "fit_ready at reset", int'(fit_ready), 1);
    check_state("R1");

    // first step: agent 0 velocity limit hit, offer while busy ignored
    run_step(1);
    chk("R6", "gbest_fit after busy offer", int'(gbest_fit), 'hFFFF);
    check_state("R2");

    send_fit(5, 1000);                     // R7/R8 first improvement
    check_state("R7");
    run_step(0);                           // position clamp reached on dim 1 here
    send_fit(5, 1000);                     // R7 equal: no copy
    send_fit(7, 1000);                     // R8 tie, higher index: no change
    check_state("R8a");
    send_fit(2, 1000);                     // R8 tie, lower index: replace
    send_fit(4, 1200);                     // R7 better personal only
    send_fit(6, 500);                      // R8 strict improvement
    check_state("R8b");

    for (int r = 0; r < 25; r++) begin
      run_step(r == 10);
      send_fit((r * 3) % A, 600 - r * 13);
      send_fit((r * 7 + 1) % A, 450 - r * 5);
    end
    check_state("R3");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule